// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits behind a receive deframer and gives one verdict per frame: pass to the host buffer, or discard. The deframer marks the opening of a frame with a one-cycle start strobe. At the closing strobe it presents the frame's metadata: destination address, EtherType, opcode and quanta words, the external perfect-match and multicast-hash results, byte length, CRC status and the PHY receive-error flag. One cycle after the closing strobe the block pulses either accept or drop. When the frame is a flow-control pause frame and flow control is on, it also pulses a pause request toward the transmitter and presents the quanta with it.

An 8-bit control register sets the behaviour. It holds a run bit, a self-clearing restart bit and six relaxation bits. Every bit resets to 0, so the block comes up halted. Clearing the run bit does not cut off a frame that is already open. The frame finishes and gets its verdict, and only then does the block halt. Until that moment the run bit reads back as 1.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, the register reads 0 and `running` is 0. No accept, drop or pause pulse appears.
- R2: Without promiscuous mode, a frame is unicast when address bit 40 (the group bit of the first byte) is 0, and it passes only when `perfectHit` is set. A frame with bit 40 set passes on `perfectHit` or `hashHit`.
- R3: With bit 7 (broadcast filter) set, an all-ones destination is dropped. With bit 7 clear and no promiscuous mode, an all-ones destination is accepted.
- R4: With bit 5 (promiscuous) set, the address, hash and broadcast-filter checks are all skipped. Error and length checks still apply.
- R5: A frame with `crcGood` low or `phyErr` high is dropped, unless bit 6 (error bypass) is set.
- R6: A frame whose `frmLen` is below 64 is dropped, unless bit 4 (runt accept) is set. A length of exactly 64 is not a runt.
- R7: A frame is a pause frame when its destination is 01-80-C2-00-00-01, its EtherType is 0x8808 and its opcode is 0x0001. A pause frame is accepted only when bit 3 (keep pause) is set and it passes the error and length checks. The address mode plays no part. Otherwise it is dropped.
- R8: With bit 2 (flow control) set, a pause frame that has good CRC and no PHY error pulses `pauseReq`, and `pauseQuanta` carries its quanta. Bit 3 and bit 6 do not change this.
- R9: For each frame that opens while the block runs, exactly one of `frmAccept` and `frmDrop` pulses, in the cycle after `frmEnd`.
- R10: Writing 0 to bit 1 (run) while a frame is open lets that frame complete and get its verdict. Bit 1 and `running` stay 1 until then and fall to 0 after it.
- R11: While halted, any frame that arrives produces no output.
- R12: Writing 1 to bit 0 (restart) abandons the open frame without a verdict. Bit 0 reads 1 in the cycle after the write and 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write value |
| cfgRdData | output | 8 | Control register read value |
| frmStart | input | 1 | Frame opening strobe |
| frmEnd | input | 1 | Frame closing strobe, metadata valid |
| dstAddr | input | 48 | Destination address, first byte in bits 47:40 |
| etherType | input | 16 | EtherType word |
| opcode | input | 16 | Control opcode word |
| quantaIn | input | 16 | Pause quanta word |
| perfectHit | input | 1 | Perfect address match result |
| hashHit | input | 1 | Multicast hash match result |
| frmLen | input | 14 | Frame length in bytes |
| crcGood | input | 1 | CRC check passed |
| phyErr | input | 1 | PHY receive error seen |
| frmAccept | output | 1 | Frame passed to host |
| frmDrop | output | 1 | Frame discarded |
| pauseReq | output | 1 | Pause request to transmitter |
| pauseQuanta | output | 16 | Quanta of last pause request |
| running | output | 1 | Block is not halted |

## Verification
The hardest cases to reach are the two control changes that land in the middle of a frame. One is a halt request that must wait for the open frame to finish. The other is a restart that must discard the open frame. The bench opens a frame and writes the control register before sending the closing strobe. It then reads back the run and restart bits in the cycles between, and watches that only the permitted verdict appears. Beyond that, the bench sweeps all 64 settings of the six relaxation bits against twelve frame shapes and derives each expected verdict from the rules.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CTRL_W   = 8;
  localparam int ADDR_W   = 48;
  localparam int WORD_W   = 16;
  localparam int CFG_RST  = 0;
  localparam int CFG_EN   = 1;
  localparam int CFG_FC   = 2;
  localparam int CFG_KP   = 3;
  localparam int CFG_RUNT = 4;
  localparam int CFG_PROM = 5;
  localparam int CFG_NOCRC = 6;
  localparam int CFG_BCF  = 7;
  localparam int GROUP_BIT = 40;
  localparam logic [ADDR_W-1:0] PAUSE_DA = 48'h0180C2000001;
  localparam logic [WORD_W-1:0] PAUSE_ET = 16'h8808;
  localparam logic [WORD_W-1:0] PAUSE_OP = 16'h0001;

  typedef enum logic [1:0] {ST_HALTED, ST_READY, ST_RECV} rxState_t;

  typedef struct packed {
    logic bcastFilter;
    logic noErrCheck;
    logic promisc;
    logic runtOk;
    logic keepPause;
    logic flowCtl;
  } filtCfg_t;

  typedef struct packed {
    logic decide;
  } ctrlStrobe_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CTRL_W-1:0] cfgWrData,
  input  logic              frmStart,
  input  logic              frmEnd,
  output filtCfg_t          cfg,
  output ctrlStrobe_t       strobe,
  output logic              running,
  output logic [CTRL_W-1:0] cfgRdData
);
  logic [CTRL_W-1:CFG_FC] relaxReg;
  logic enReg;
  logic rstPend;
  rxState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relaxReg <= '0;
      enReg    <= 1'b0;
      rstPend  <= 1'b0;
      state    <= ST_HALTED;
    end else begin
      rstPend <= cfgWrEn & cfgWrData[CFG_RST];
      if (cfgWrEn) begin
        enReg    <= cfgWrData[CFG_EN];
        relaxReg <= cfgWrData[CTRL_W-1:CFG_FC];
      end
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    if (rstPend) begin
      nextState = enReg ? ST_READY : ST_HALTED;
    end else begin
      case (state)
        ST_HALTED: if (enReg) nextState = ST_READY;
        ST_READY: begin
          if (!enReg)        nextState = ST_HALTED;
          else if (frmStart) nextState = ST_RECV;
        end
        ST_RECV:   if (frmEnd) nextState = enReg ? ST_READY : ST_HALTED;
        default:   nextState = ST_HALTED;
      endcase
    end
  end

  assign strobe.decide   = (state == ST_RECV) && frmEnd && !rstPend;
  assign running         = (state != ST_HALTED);
  assign cfg.bcastFilter = relaxReg[CFG_BCF];
  assign cfg.noErrCheck  = relaxReg[CFG_NOCRC];
  assign cfg.promisc     = relaxReg[CFG_PROM];
  assign cfg.runtOk      = relaxReg[CFG_RUNT];
  assign cfg.keepPause   = relaxReg[CFG_KP];
  assign cfg.flowCtl     = relaxReg[CFG_FC];
  assign cfgRdData       = {relaxReg, enReg | running, rstPend};
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtCfg_t          cfg,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [WORD_W-1:0] etherType,
  input  logic [WORD_W-1:0] opcode,
  input  logic [WORD_W-1:0] quantaIn,
  input  logic              perfectHit,
  input  logic              hashHit,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              crcGood,
  input  logic              phyErr,
  output logic              frmAccept,
  output logic              frmDrop,
  output logic              pauseReq,
  output logic [WORD_W-1:0] pauseQuanta
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic isBcast, isGroup, isPause, cleanRx;
  logic addrOk, errOk, lenOk, passAll, actPause;

  always_comb begin
    isBcast = &dstAddr;
    isGroup = dstAddr[GROUP_BIT];
    isPause = (dstAddr == PAUSE_DA) && (etherType == PAUSE_ET) && (opcode == PAUSE_OP);
    cleanRx = crcGood && !phyErr;
    if (cfg.promisc)  addrOk = 1'b1;
    else if (isBcast) addrOk = !cfg.bcastFilter;
    else if (isGroup) addrOk = perfectHit || hashHit;
    else              addrOk = perfectHit;
    errOk    = cfg.noErrCheck || cleanRx;
    lenOk    = cfg.runtOk || (frmLen >= MIN_LEN_V);
    passAll  = errOk && lenOk && (isPause ? cfg.keepPause : addrOk);
    actPause = isPause && cfg.flowCtl && cleanRx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmAccept   <= 1'b0;
      frmDrop     <= 1'b0;
      pauseReq    <= 1'b0;
      pauseQuanta <= '0;
    end else begin
      frmAccept <= strobe.decide && passAll;
      frmDrop   <= strobe.decide && !passAll;
      pauseReq  <= strobe.decide && actPause;
      if (strobe.decide && actPause) pauseQuanta <= quantaIn;
    end
  end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CTRL_W-1:0] cfgWrData,
  output logic [CTRL_W-1:0] cfgRdData,
  input  logic              frmStart,
  input  logic              frmEnd,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [WORD_W-1:0] etherType,
  input  logic [WORD_W-1:0] opcode,
  input  logic [WORD_W-1:0] quantaIn,
  input  logic              perfectHit,
  input  logic              hashHit,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              crcGood,
  input  logic              phyErr,
  output logic              frmAccept,
  output logic              frmDrop,
  output logic              pauseReq,
  output logic [WORD_W-1:0] pauseQuanta,
  output logic              running
);
  filtCfg_t    cfg;
  ctrlStrobe_t strobe;

  rxf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .frmStart(frmStart), .frmEnd(frmEnd), .cfg(cfg), .strobe(strobe),
    .running(running), .cfgRdData(cfgRdData)
  );

  rxf_datapath #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .dstAddr(dstAddr), .etherType(etherType), .opcode(opcode), .quantaIn(quantaIn),
    .perfectHit(perfectHit), .hashHit(hashHit), .frmLen(frmLen),
    .crcGood(crcGood), .phyErr(phyErr), .frmAccept(frmAccept), .frmDrop(frmDrop),
    .pauseReq(pauseReq), .pauseQuanta(pauseQuanta)
  );
endmodule

// File: rtl/rx_accept_filter_chk.sv
module rx_accept_filter_chk
  import rxf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [CTRL_W-1:0] cfgWrData,
  input logic [CTRL_W-1:0] cfgRdData,
  input logic              frmEnd,
  input logic              frmAccept,
  input logic              frmDrop,
  input logic              pauseReq,
  input logic              running
);
  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frmAccept && frmDrop));
  // R9
  verdict_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmAccept || frmDrop) |-> $past(frmEnd));
  // R11
  verdict_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmAccept || frmDrop) |-> $past(running));
  // R8
  pause_needs_fc_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |-> $past(cfgRdData[CFG_FC]));
  // R8
  pause_has_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |-> (frmAccept || frmDrop));
  // R12
  restart_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[CFG_RST] |-> $past(cfgWrEn && cfgWrData[CFG_RST]));
endmodule

bind rx_accept_filter rx_accept_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .frmEnd(frmEnd), .frmAccept(frmAccept),
  .frmDrop(frmDrop), .pauseReq(pauseReq), .running(running)
);

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic frmStart = 1'b0, frmEnd = 1'b0;
  logic [47:0] dstAddr = '0;
  logic [15:0] etherType = '0, opcode = '0, quantaIn = '0;
  logic perfectHit = 1'b0, hashHit = 1'b0, crcGood = 1'b0, phyErr = 1'b0;
  logic [13:0] frmLen = '0;
  logic frmAccept, frmDrop, pauseReq, running;
  logic [15:0] pauseQuanta;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx_accept_filter uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .frmStart(frmStart), .frmEnd(frmEnd), .dstAddr(dstAddr), .etherType(etherType),
    .opcode(opcode), .quantaIn(quantaIn), .perfectHit(perfectHit), .hashHit(hashHit),
    .frmLen(frmLen), .crcGood(crcGood), .phyErr(phyErr), .frmAccept(frmAccept),
    .frmDrop(frmDrop), .pauseReq(pauseReq), .pauseQuanta(pauseQuanta), .running(running)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic setMeta(input int kind);
    dstAddr = 48'h00AA_BB00_0001; etherType = 16'h0800; opcode = 16'h0000;
    quantaIn = 16'h0; perfectHit = 1'b1; hashHit = 1'b0; frmLen = 14'd100;
    crcGood = 1'b1; phyErr = 1'b0;
    case (kind)
      1: perfectHit = 1'b0;
      2: begin dstAddr = 48'h0100_5E00_0007; perfectHit = 1'b0; hashHit = 1'b1; end
      3: begin dstAddr = 48'h0100_5E00_0007; perfectHit = 1'b0; end
      4: begin dstAddr = '1; perfectHit = 1'b0; end
      5, 10: begin
        dstAddr = 48'h0180_C200_0001; etherType = 16'h8808; opcode = 16'h0001;
        quantaIn = 16'h1200 + 16'(kind); perfectHit = 1'b0; frmLen = 14'd64;
        if (kind == 10) crcGood = 1'b0;
      end
      6: frmLen = 14'd63;
      7: frmLen = 14'd64;
      8: crcGood = 1'b0;
      9: phyErr = 1'b1;
      11: dstAddr = 48'h0300_0000_0042;
      default: ;
    endcase
  endtask

  task automatic pulseStart();
    @(negedge clk); frmStart = 1'b1;
    @(negedge clk); frmStart = 1'b0;
  endtask

  task automatic pulseEnd();
    frmEnd = 1'b1;
    @(negedge clk); frmEnd = 1'b0;
  endtask

  // Expected verdict derived from the requirement text, per frame shape.
  function automatic void expect_of(input int kind, input logic [5:0] r,
                                    output bit acc, output bit pz);
    bit fc = r[0], kp = r[1], runt = r[2], prom = r[3], noErr = r[4], bcf = r[5];
    bit pauseFrame = (kind == 5) || (kind == 10);
    bit clean = !(kind == 8 || kind == 9 || kind == 10);
    bit shortF = (kind == 6);
    bit addrPass;
    case (kind)
      1, 3: addrPass = prom;
      4:    addrPass = prom || !bcf;
      default: addrPass = 1'b1;
    endcase
    if (pauseFrame) addrPass = kp;
    acc = addrPass && (clean || noErr) && (!shortF || runt);
    pz  = pauseFrame && fc && clean;
  endfunction

  function automatic string tag_of(input int kind);
    case (kind)
      0, 1, 2, 3, 11: return "R2 R4 address";
      4: return "R3 broadcast";
      5: return "R7 R8 pause";
      6, 7: return "R6 length";
      8, 9: return "R5 errors";
      default: return "R8 pause bad crc";
    endcase
  endfunction

  initial begin : watchdog
    int n = 0;
    while (!finished && n < 150000) begin @(posedge clk); n++; end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit expA, expP;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 readback", {24'h0, cfgRdData}, 32'h0);
    check("R1 running", {31'h0, running}, 32'h0);
    rstN = 1'b1;
    setMeta(0);
    pulseStart(); pulseEnd();
    check("R1 R11 no verdict from reset", {29'h0, frmAccept, frmDrop, pauseReq}, 32'h0);

    // Sweep every relaxation setting against every frame shape.
    for (int r = 0; r < 64; r++) begin
      writeCfg({r[5:0], 2'b10});
      @(negedge clk);
      for (int k = 0; k < 12; k++) begin
        pulseStart();
        setMeta(k);
        frmEnd = 1'b1;
        @(negedge clk); frmEnd = 1'b0;
        expect_of(k, r[5:0], expA, expP);
        check({tag_of(k), " R9 verdict"}, {30'h0, frmAccept, frmDrop}, {30'h0, expA, !expA});
        check({tag_of(k), " pauseReq"}, {31'h0, pauseReq}, {31'h0, expP});
        if (expP) check("R8 quanta", {16'h0, pauseQuanta}, {16'h0, 16'h1200 + 16'(k)});
      end
    end

    // R10 halt request during an open frame
    writeCfg(8'h02);
    @(negedge clk);
    setMeta(0);
    pulseStart();
    writeCfg(8'h00);
    check("R10 run bit held", {31'h0, cfgRdData[1]}, 32'h1);
    check("R10 running held", {31'h0, running}, 32'h1);
    pulseEnd();
    check("R10 frame finished", {30'h0, frmAccept, frmDrop}, 32'h2);
    check("R10 halted", {30'h0, running, cfgRdData[1]}, 32'h0);

    // R11 frames while halted are ignored
    begin
      int seen = 0;
      pulseStart();
      frmEnd = 1'b1;
      @(negedge clk); frmEnd = 1'b0;
      seen += int'(frmAccept || frmDrop || pauseReq);
      @(negedge clk);
      seen += int'(frmAccept || frmDrop || pauseReq);
      check("R11 halted ignores", seen, 0);
    end

    // R12 restart abandons open frame
    writeCfg(8'h02);
    @(negedge clk);
    pulseStart();
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = 8'h03;
    @(negedge clk); cfgWrEn = 1'b0;
    check("R12 restart bit set", {31'h0, cfgRdData[0]}, 32'h1);
    @(negedge clk);
    check("R12 restart bit cleared", {31'h0, cfgRdData[0]}, 32'h0);
    pulseEnd();
    check("R12 no verdict", {30'h0, frmAccept, frmDrop}, 32'h0);
    check("R12 still running", {31'h0, running}, 32'h1);
    pulseStart(); pulseEnd();
    check("R12 next frame decided", {30'h0, frmAccept, frmDrop}, 32'h2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule